// File: doc/BRIEF.md
# Vector Element Issue Sequencer

This block turns one scalar instruction, marked for repetition, into a stream of ordinary scalar micro-ops, one for each vector element. The front end hands over the decoded operation, a destination and two source register numbers, one repeat tag for each of the three operands, a vector length and the value of an integer predicate register. While the loop runs the block keeps the program counter stalled. It walks an element index from zero up to the length minus one. Each element whose predicate bit is set goes out on a valid/ready port, and elements whose bit is clear are dropped without a micro-op.

An operand with its tag set moves to the next register on every element. An operand with its tag clear stays on its base register. The opcode is never changed, so scalar-scalar, scalar-vector and vector-vector forms all come from the same loop. Every micro-op carries its element index, so the execution side can put results back in order. When the last element has been handled, a one-cycle pulse tells the fetch stage to move the program counter on.

Top module: `vseq_issue`

## Requirements
- R1: `in_ready` is 1 exactly when the block is idle. A `start` pulse while busy is ignored and leaves the running sequence unchanged.
- R2: `pc_hold` is 1 from the cycle after a non-empty instruction is accepted until its last element is handled. `done` is 1 for exactly one cycle, the first cycle after that, with `pc_hold` already 0.
- R3: With `vl` = 0 the block issues no micro-op, `pc_hold` stays 0, and `done` is 1 in the cycle after acceptance.
- R4: Element i (0 <= i < vl) is issued only when bit i of `pred` is 1. Elements leave in increasing order, and `uop_elem` equals i.
- R5: For element i, an operand whose tag bit is 1 uses register base+i, and an operand whose tag bit is 0 uses its base register. The tags are `vec_rd`, `vec_rs1` and `vec_rs2`.
- R6: `uop_op` equals the accepted `op` on every micro-op.
- R7: While `uop_valid` is 1 and `uop_ready` is 0, the micro-op and all its fields stay unchanged in the next cycle.
- R8: A masked-off element takes exactly one cycle and issues nothing. With `uop_ready` held at 1, `done` rises exactly `vl` cycles after the first running cycle.
- R9: If base+i of a repeating operand exceeds 31, the issued register number wraps modulo 32 and `uop_err` is 1 on that micro-op. Otherwise `uop_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Present a new instruction |
| in_ready | output | 1 | Idle, so a new instruction can be taken |
| op | input | 8 | Scalar opcode |
| rd | input | 5 | Destination base register |
| rs1 | input | 5 | First source base register |
| rs2 | input | 5 | Second source base register |
| vec_rd | input | 1 | Destination steps per element |
| vec_rs1 | input | 1 | First source steps per element |
| vec_rs2 | input | 1 | Second source steps per element |
| vl | input | 5 | Element count, 0 to 16 |
| pred | input | 16 | Predicate mask, bit i enables element i |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Downstream takes the micro-op |
| uop_op | output | 8 | Opcode of the micro-op |
| uop_rd | output | 5 | Destination register of the micro-op |
| uop_rs1 | output | 5 | First source register of the micro-op |
| uop_rs2 | output | 5 | Second source register of the micro-op |
| uop_elem | output | 4 | Element index |
| uop_err | output | 1 | A register number ran past the register file |
| pc_hold | output | 1 | Program counter stalled |
| done | output | 1 | One-cycle pulse to advance the program counter |

## Verification
The assertions assume that `vl` never exceeds 16 and that `start` is sampled only on a clock edge. The hold property also assumes that the downstream never withdraws a micro-op it has not taken. The bench keeps every length in range. It drives `start` and `uop_ready` only on falling edges, and it changes `uop_ready` only through a fixed pattern, so each stall is followed by an accepting cycle.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    localparam int OP_W    = 8;
    localparam int REG_W   = 5;
    localparam int IDX_W   = 4;
    localparam int MAX_VL  = 1 << IDX_W;
    localparam int VL_W    = IDX_W + 1;
    localparam int N_OPND  = 3;
    localparam int SUM_W   = ((REG_W > IDX_W) ? REG_W : IDX_W) + 1;

    typedef logic [REG_W-1:0] reg_t;

    typedef enum logic {ST_IDLE, ST_RUN} seq_st_e;

    // tag bit 0: destination, 1: first source, 2: second source
    typedef struct packed {
        logic [OP_W-1:0]   op;
        reg_t              rd;
        reg_t              rs1;
        reg_t              rs2;
        logic [N_OPND-1:0] tag;
    } instr_t;
endpackage

// File: rtl/vseq_elem_ctr.sv
module vseq_elem_ctr
    import vseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VL_W-1:0]   vl,
    input  logic [MAX_VL-1:0] pred,
    input  logic              uop_ready,
    output logic              accept,
    output logic              busy,
    output logic [IDX_W-1:0]  idx,
    output logic              elem_live,
    output logic              done
);
    seq_st_e           st_q;
    logic [VL_W-1:0]   len_q;
    logic [MAX_VL-1:0] mask_q;
    logic [IDX_W-1:0]  idx_q;
    logic              done_q;
    logic              step;
    logic              last;

    assign accept    = start && (st_q == ST_IDLE);
    assign busy      = (st_q == ST_RUN);
    assign idx       = idx_q;
    assign done      = done_q;
    assign elem_live = busy && mask_q[idx_q];
    assign step      = busy && (!mask_q[idx_q] || uop_ready);
    assign last      = (({1'b0, idx_q} + VL_W'(1)) == len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            len_q  <= '0;
            mask_q <= '0;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                len_q  <= vl;
                mask_q <= pred;
                idx_q  <= '0;
                if (vl == '0) done_q <= 1'b1;
                else          st_q   <= ST_RUN;
            end else if (step) begin
                if (last) begin
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    // R4
    elem_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> ({1'b0, idx_q} < len_q));
endmodule

// File: rtl/vseq_reg_off.sv
module vseq_reg_off
    import vseq_pkg::*;
(
    input  reg_t             base,
    input  logic             step_en,
    input  logic [IDX_W-1:0] idx,
    output reg_t             regn,
    output logic             ovf
);
    logic [SUM_W-1:0] sum;

    assign sum  = SUM_W'(base) + (step_en ? SUM_W'(idx) : '0);
    assign regn = sum[REG_W-1:0];
    assign ovf  = |sum[SUM_W-1:REG_W];
endmodule

// File: rtl/vseq_issue.sv
module vseq_issue
    import vseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              in_ready,
    input  logic [OP_W-1:0]   op,
    input  logic [REG_W-1:0]  rd,
    input  logic [REG_W-1:0]  rs1,
    input  logic [REG_W-1:0]  rs2,
    input  logic              vec_rd,
    input  logic              vec_rs1,
    input  logic              vec_rs2,
    input  logic [VL_W-1:0]   vl,
    input  logic [MAX_VL-1:0] pred,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic [OP_W-1:0]   uop_op,
    output logic [REG_W-1:0]  uop_rd,
    output logic [REG_W-1:0]  uop_rs1,
    output logic [REG_W-1:0]  uop_rs2,
    output logic [IDX_W-1:0]  uop_elem,
    output logic              uop_err,
    output logic              pc_hold,
    output logic              done
);
    instr_t            ins_q;
    logic              accept;
    logic              busy;
    logic              live;
    logic [IDX_W-1:0]  idx;
    reg_t              base_a [N_OPND];
    reg_t              regn_a [N_OPND];
    logic [N_OPND-1:0] ovf_v;

    vseq_elem_ctr u_ctr (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .vl        (vl),
        .pred      (pred),
        .uop_ready (uop_ready),
        .accept    (accept),
        .busy      (busy),
        .idx       (idx),
        .elem_live (live),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_q <= '0;
        end else if (accept) begin
            ins_q <= '{op: op, rd: rd, rs1: rs1, rs2: rs2,
                       tag: {vec_rs2, vec_rs1, vec_rd}};
        end
    end

    assign base_a[0] = ins_q.rd;
    assign base_a[1] = ins_q.rs1;
    assign base_a[2] = ins_q.rs2;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        vseq_reg_off u_off (
            .base    (base_a[g]),
            .step_en (ins_q.tag[g]),
            .idx     (idx),
            .regn    (regn_a[g]),
            .ovf     (ovf_v[g])
        );
    end

    assign in_ready  = !busy;
    assign pc_hold   = busy;
    assign uop_valid = live;
    assign uop_op    = ins_q.op;
    assign uop_rd    = regn_a[0];
    assign uop_rs1   = regn_a[1];
    assign uop_rs2   = regn_a[2];
    assign uop_elem  = idx;
    assign uop_err   = live && (|ovf_v);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_op) &&
        $stable(uop_rd) && $stable(uop_rs1) && $stable(uop_rs2) && $stable(uop_elem)));
    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (in_ready && !pc_hold));
    // R2
    release_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pc_hold) |-> done);
    // R3
    empty_len_chk: assert property (@(posedge clk) disable iff (rst)
        (start && in_ready && (vl == '0)) |=> (done && !pc_hold));
    // R1
    issue_busy_chk: assert property (@(posedge clk) disable iff (rst)
        uop_valid |-> pc_hold);
endmodule

// File: tb/vseq_issue_test.sv
`timescale 1ns/1ps
module vseq_issue_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        in_ready;
    logic [7:0]  op = '0;
    logic [4:0]  rd = '0, rs1 = '0, rs2 = '0;
    logic        vec_rd = 1'b0, vec_rs1 = 1'b0, vec_rs2 = 1'b0;
    logic [4:0]  vl = '0;
    logic [15:0] pred = '0;
    logic        uop_valid, uop_ready = 1'b1;
    logic [7:0]  uop_op;
    logic [4:0]  uop_rd, uop_rs1, uop_rs2;
    logic [3:0]  uop_elem;
    logic        uop_err, pc_hold, done;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    vseq_issue uut (
        .clk(clk), .rst(rst), .start(start), .in_ready(in_ready),
        .op(op), .rd(rd), .rs1(rs1), .rs2(rs2),
        .vec_rd(vec_rd), .vec_rs1(vec_rs1), .vec_rs2(vec_rs2),
        .vl(vl), .pred(pred),
        .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op),
        .uop_rd(uop_rd), .uop_rs1(uop_rs1), .uop_rs2(uop_rs2),
        .uop_elem(uop_elem), .uop_err(uop_err),
        .pc_hold(pc_hold), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Runs one instruction and compares every micro-op with a reference loop.
    // bp: apply backpressure; poke: pulse start while busy with another rd.
    task automatic run_seq(input string name, input logic [7:0] o,
                           input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2,
                           input logic [2:0] tg, input int len, input logic [15:0] pm,
                           input bit bp, input bit poke);
        int exp_rd[16], exp_s1[16], exp_s2[16], exp_el[16], exp_er[16];
        int n_exp = 0;
        int k = 0;
        int cyc = 0;
        bit seen_done = 0;
        bit stalled = 0;
        int st_rd = 0, st_el = 0;
        for (int i = 0; i < len; i++) begin
            if (pm[i]) begin
                int a = d  + (tg[0] ? i : 0);
                int b = s1 + (tg[1] ? i : 0);
                int c = s2 + (tg[2] ? i : 0);
                exp_rd[n_exp] = a % 32;
                exp_s1[n_exp] = b % 32;
                exp_s2[n_exp] = c % 32;
                exp_el[n_exp] = i;
                exp_er[n_exp] = (a > 31 || b > 31 || c > 31) ? 1 : 0;
                n_exp++;
            end
        end
        @(negedge clk);
        chk(in_ready == 1'b1, {name, " R1 ready before start"}, int'(in_ready), 1);
        op = o; rd = d; rs1 = s1; rs2 = s2;
        {vec_rs2, vec_rs1, vec_rd} = tg;
        vl = 5'(len); pred = pm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (len == 0) begin
            chk(done == 1'b1, {name, " R3 done after empty"}, int'(done), 1);
            chk(pc_hold == 1'b0, {name, " R3 pc not held"}, int'(pc_hold), 0);
            chk(uop_valid == 1'b0, {name, " R3 no issue"}, int'(uop_valid), 0);
            @(negedge clk);
            chk(done == 1'b0, {name, " R2 single pulse"}, int'(done), 0);
            return;
        end
        while (cyc < 200) begin
            if (done) begin
                seen_done = 1;
                break;
            end
            chk(pc_hold == 1'b1, {name, " R2 pc held while running"}, int'(pc_hold), 1);
            chk(in_ready == 1'b0, {name, " R1 busy not ready"}, int'(in_ready), 0);
            if (poke && cyc == 1) begin
                start = 1'b1; rd = d ^ 5'd7;
            end else begin
                start = 1'b0; rd = d;
            end
            uop_ready = bp ? ((cyc % 3) != 1) : 1'b1;
            if (stalled) begin
                chk(uop_valid && uop_rd == 5'(st_rd) && uop_elem == 4'(st_el),
                    {name, " R7 held under stall"}, int'(uop_elem), st_el);
                stalled = 0;
            end
            if (uop_valid) begin
                chk(uop_op == o, {name, " R6 opcode"}, int'(uop_op), int'(o));
                if (k < n_exp) begin
                    chk(int'(uop_elem) == exp_el[k], {name, " R4 element order"}, int'(uop_elem), exp_el[k]);
                    chk(int'(uop_rd) == exp_rd[k] && int'(uop_rs1) == exp_s1[k] &&
                        int'(uop_rs2) == exp_s2[k], {name, " R5 register numbers"},
                        int'(uop_rd), exp_rd[k]);
                    chk(int'(uop_err) == exp_er[k], {name, " R9 overflow flag"}, int'(uop_err), exp_er[k]);
                end else begin
                    chk(0, {name, " R4 extra micro-op"}, k + 1, n_exp);
                end
                if (uop_ready) k++;
                else begin
                    stalled = 1; st_rd = int'(uop_rd); st_el = int'(uop_elem);
                end
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0; rd = d; uop_ready = 1'b1;
        chk(seen_done, {name, " R2 done seen"}, int'(seen_done), 1);
        chk(k == n_exp, {name, " R4 issue count"}, k, n_exp);
        chk(pc_hold == 1'b0 && in_ready == 1'b1, {name, " R2 released at done"}, int'(pc_hold), 0);
        if (!bp) chk(cyc == len, {name, " R8 one cycle per element"}, cyc, len);
        @(negedge clk);
        chk(done == 1'b0, {name, " R2 single pulse"}, int'(done), 0);
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1 && pc_hold == 1'b0, "R1 reset idle", int'(in_ready), 1);
        chk(uop_valid == 1'b0 && done == 1'b0, "R2 reset quiet", int'(uop_valid), 0);
    endtask

    task automatic t_vec_vec();   run_seq("vv",     8'h21, 5'd2, 5'd8, 5'd16, 3'b111, 4, 16'hFFFF, 0, 0); endtask
    task automatic t_mixed();     run_seq("mixed",  8'h5A, 5'd3, 5'd9, 5'd1,  3'b101, 6, 16'hFFFF, 0, 0); endtask
    task automatic t_masked();    run_seq("masked", 8'h33, 5'd4, 5'd0, 5'd7,  3'b011, 8, 16'h00A5, 0, 0); endtask
    task automatic t_backpress(); run_seq("bp",     8'h77, 5'd1, 5'd2, 5'd3,  3'b111, 7, 16'h005B, 1, 0); endtask
    task automatic t_empty();     run_seq("vl0",    8'h10, 5'd5, 5'd6, 5'd7,  3'b111, 0, 16'hFFFF, 0, 0); endtask
    task automatic t_single();    run_seq("single", 8'h42, 5'd30, 5'd31, 5'd0, 3'b000, 1, 16'h0001, 0, 0); endtask
    task automatic t_full();      run_seq("full",   8'h99, 5'd20, 5'd31, 5'd0, 3'b101, 16, 16'hFFFF, 0, 0); endtask
    task automatic t_all_masked();run_seq("nomask",8'h0F, 5'd1, 5'd1, 5'd1,  3'b111, 5, 16'h0000, 0, 0); endtask
    task automatic t_busy_poke(); run_seq("poke",   8'h66, 5'd10, 5'd12, 5'd14, 3'b110, 5, 16'h001F, 1, 1); endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_vec_vec();
        t_mixed();
        t_masked();
        t_backpress();
        t_empty();
        t_single();
        t_full();
        t_all_masked();
        t_busy_poke();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule